// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block is the control logic on the converter side that decides when the analog self-calibration runs and what the outputs do while it runs. After reset it waits out a power-up settling delay. That delay advances only on cycles where the input clock is reported valid. It then launches the first calibration. Later calibrations are launched on command, by a low-then-high cycle on an external calibrate pin. Glitches on that pin are rejected by a minimum-phase filter.

The analog calibration engine is modelled as a busy interval of fixed length. During that interval the block raises a busy status, disables the data outputs, and decides two things from a keep-clock configuration bit: whether the output data clock keeps running, and whether a termination-trim step is requested. The power-up calibration always trims. This guarantees at least one trim after every reset.

Top module: `adc_cal_seq`

## Requirements
- R1: During reset and directly after it, `cal_busy` is 0, `data_oe` is 1, `dclk_oe` is 1 and `trim_go` is 0.
- R2: The power-up delay counts only cycles where `clk_ok` is 1. With `clk_ok` held at 0, no calibration starts. With the pin low and the short delay selected, `cal_busy` rises SHORT_DLY to SHORT_DLY+4 cycles after `clk_ok` goes to 1.
- R3: When `dly_long` is 1 and `ser_cfg` is 0, the delay is LONG_DLY cycles, and `cal_busy` rises LONG_DLY to LONG_DLY+4 cycles after reset. When `ser_cfg` is 1, the short delay is used whatever `dly_long` is.
- R4: If the calibrate pin is high at power-up, the first calibration waits after the delay has ended. It starts only after the pin has been accepted low and then accepted high.
- R5: After the power-up calibration, an accepted low-then-high cycle on `cal_pin` starts one on-command calibration.
- R6: A pin level is accepted only after it has held for MIN_PHASE consecutive synchronized cycles. A high pulse shorter than that starts no calibration.
- R7: `cal_busy` stays high for exactly CAL_CYCLES cycles, and `data_oe` is 0 for that whole interval.
- R8: An on-command calibration that starts with `keep_dclk` at 0 holds `dclk_oe` at 0 for the interval. It gives a single-cycle `trim_go` pulse in the interval's first cycle.
- R9: An on-command calibration that starts with `keep_dclk` at 1 keeps `dclk_oe` at 1 and gives no `trim_go` pulse.
- R10: The power-up calibration gives the `trim_go` pulse and stops `dclk_oe` even when `keep_dclk` is 1.
- R11: A low-then-high cycle on the pin that completes while a calibration is running starts no further calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter control clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| clk_ok | input | 1 | Input clock is valid; gates the power-up delay |
| ser_cfg | input | 1 | Serial-configured mode; forces the short delay |
| dly_long | input | 1 | Requests the long power-up delay |
| cal_pin | input | 1 | Asynchronous external calibrate pin |
| keep_dclk | input | 1 | Keep-clock / skip-trim configuration bit (reset default 0) |
| cal_busy | output | 1 | High while a calibration interval runs |
| data_oe | output | 1 | Data output enable |
| dclk_oe | output | 1 | Output data clock enable |
| trim_go | output | 1 | One-cycle termination-trim request |

## Verification
The hardest case to reach is a pin that is already high when reset ends. In that case the block must stay idle past the end of the delay, and it must not treat the high level it first accepts as a trigger. The bench releases reset with the pin high, the long delay selected and the keep-clock bit set. It waits well past the long delay and confirms that no calibration has started. It then drives a full low-then-high cycle and expects a calibration that trims. A second hard case is a trigger that arrives during a running interval. The bench drives two complete filtered phases on the pin inside one calibration and checks that only one interval follows.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic [1:0] {
        ST_PU_DLY  = 2'd0,
        ST_PU_GATE = 2'd1,
        ST_CAL     = 2'd2,
        ST_RUN     = 2'd3
    } seq_st_e;

    typedef struct packed {
        logic keep;
        logic trim;
    } cal_kind_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic cal_kind_t kind_for(input logic powerup, input logic keep_bit);
        cal_kind_t k;
        k.keep = powerup ? 1'b0 : keep_bit;
        k.trim = powerup ? 1'b1 : ~keep_bit;
        return k;
    endfunction

endpackage

// File: rtl/cal_pin_filt.sv
module cal_pin_filt #(
    parameter int unsigned MIN_PHASE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic lvl_q,
    output logic lvl_ok,
    output logic rise
);
    localparam int unsigned RW = $clog2(MIN_PHASE + 1);
    localparam logic [RW-1:0] RMAX = RW'(MIN_PHASE);
    localparam logic [RW-1:0] RACC = RW'(MIN_PHASE - 1);

    logic          s1, s2, cand;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b0;
            s2     <= 1'b0;
            cand   <= 1'b0;
            run    <= '0;
            lvl_q  <= 1'b0;
            lvl_ok <= 1'b0;
            rise   <= 1'b0;
        end else begin
            s1   <= pin;
            s2   <= s1;
            rise <= 1'b0;
            if (s2 != cand) begin
                cand <= s2;
                run  <= RW'(1);
            end else begin
                if (run < RMAX) run <= run + RW'(1);
                if (run >= RACC && (!lvl_ok || lvl_q != cand)) begin
                    lvl_q  <= cand;
                    lvl_ok <= 1'b1;
                    rise   <= lvl_ok & ~lvl_q & cand;
                end
            end
        end
    end
endmodule

// File: rtl/cal_cnt.sv
module cal_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = en && (cnt >= limit - W'(1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (en)   cnt <= done ? '0 : cnt + W'(1);
    end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int unsigned SHORT_DLY  = 3_750_000,
    parameter int unsigned LONG_DLY   = 375_000_000,
    parameter int unsigned CAL_CYCLES = 1_500_000,
    parameter int unsigned MIN_PHASE  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_ok,
    input  logic ser_cfg,
    input  logic dly_long,
    input  logic cal_pin,
    input  logic keep_dclk,
    output logic cal_busy,
    output logic data_oe,
    output logic dclk_oe,
    output logic trim_go
);
    localparam int unsigned CMAX = max3(SHORT_DLY, LONG_DLY, CAL_CYCLES);
    localparam int unsigned CW   = $clog2(CMAX + 1);

    seq_st_e   st;
    cal_kind_t kind_q;
    logic      trim_q, held_hi, ok_d;
    logic      lvl_q, lvl_ok, rise;
    logic      cnt_en, cnt_done, use_long;
    logic [CW-1:0] limit;

    cal_pin_filt #(.MIN_PHASE(MIN_PHASE)) u_filt (
        .clk(clk), .rst(rst), .pin(cal_pin),
        .lvl_q(lvl_q), .lvl_ok(lvl_ok), .rise(rise)
    );

    assign use_long = dly_long & ~ser_cfg;
    assign cnt_en   = (st == ST_PU_DLY && clk_ok) || (st == ST_CAL);

    always_comb begin
        if (st == ST_CAL)  limit = CW'(CAL_CYCLES);
        else if (use_long) limit = CW'(LONG_DLY);
        else               limit = CW'(SHORT_DLY);
    end

    cal_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .en(cnt_en), .limit(limit), .done(cnt_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_PU_DLY;
            kind_q  <= '0;
            trim_q  <= 1'b0;
            held_hi <= 1'b0;
            ok_d    <= 1'b0;
        end else begin
            ok_d   <= lvl_ok;
            trim_q <= 1'b0;
            if (rise)                          held_hi <= 1'b0;
            else if (lvl_ok && !ok_d && lvl_q) held_hi <= 1'b1;
            unique case (st)
                ST_PU_DLY: if (cnt_done) st <= ST_PU_GATE;
                ST_PU_GATE: begin
                    if (ok_d && !held_hi && !rise) begin
                        st     <= ST_CAL;
                        kind_q <= kind_for(1'b1, keep_dclk);
                        trim_q <= 1'b1;
                    end
                end
                ST_CAL: if (cnt_done) st <= ST_RUN;
                ST_RUN: begin
                    if (rise) begin
                        st     <= ST_CAL;
                        kind_q <= kind_for(1'b0, keep_dclk);
                        trim_q <= kind_for(1'b0, keep_dclk).trim;
                    end
                end
                default: st <= ST_PU_DLY;
            endcase
        end
    end

    assign cal_busy = (st == ST_CAL);
    assign data_oe  = ~cal_busy;
    assign dclk_oe  = ~cal_busy | kind_q.keep;
    assign trim_go  = trim_q;
endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk (
    input logic clk,
    input logic rst,
    input logic cal_busy,
    input logic data_oe,
    input logic dclk_oe,
    input logic trim_go
);
    // R7: data disabled throughout a calibration
    assert_data_off_R7: assert property (@(posedge clk) disable iff (rst)
        cal_busy |-> !data_oe);

    // R1: outside calibration, everything is enabled
    assert_idle_enables_R1: assert property (@(posedge clk) disable iff (rst)
        !cal_busy |-> (data_oe && dclk_oe && !trim_go));

    // R8: a trim request only comes with a stopped clock inside calibration
    assert_trim_clock_stop_R8: assert property (@(posedge clk) disable iff (rst)
        trim_go |-> (cal_busy && !dclk_oe));

    // R8: trim request is a single-cycle pulse
    assert_trim_single_R8: assert property (@(posedge clk) disable iff (rst)
        trim_go |=> !trim_go);

    // R9: the clock decision holds for the whole interval
    assert_dclk_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && $past(cal_busy)) |-> $stable(dclk_oe));

    // R8: trim request only in the first cycle of an interval
    assert_trim_first_R8: assert property (@(posedge clk) disable iff (rst)
        (trim_go && $past(!rst)) |-> !$past(cal_busy));
endmodule

bind adc_cal_seq adc_cal_seq_chk u_chk (
    .clk(clk), .rst(rst), .cal_busy(cal_busy), .data_oe(data_oe),
    .dclk_oe(dclk_oe), .trim_go(trim_go)
);

// File: tb/sim_adc_cal_seq.sv
module sim_adc_cal_seq;
    localparam int SHORT = 40;
    localparam int LONG  = 200;
    localparam int CALN  = 30;
    localparam int MINP  = 4;

    typedef struct packed { logic trim; logic keep; } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_ok = 1'b0, ser_cfg = 1'b0, dly_long = 1'b0, cal_pin = 1'b0, keep_dclk = 1'b0;
    logic cal_busy, data_oe, dclk_oe, trim_go;

    int total = 0, bad = 0, n_cal = 0, len = 0;
    logic prev_busy = 1'b0;
    logic finished = 1'b0;
    exp_t expq[$];

    always #4 clk = ~clk;

    adc_cal_seq #(.SHORT_DLY(SHORT), .LONG_DLY(LONG), .CAL_CYCLES(CALN), .MIN_PHASE(MINP)) u0 (
        .clk(clk), .rst(rst), .clk_ok(clk_ok), .ser_cfg(ser_cfg), .dly_long(dly_long),
        .cal_pin(cal_pin), .keep_dclk(keep_dclk), .cal_busy(cal_busy), .data_oe(data_oe),
        .dclk_oe(dclk_oe), .trim_go(trim_go)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_busy <= 1'b0;
        end else begin
            if (cal_busy && !prev_busy) begin
                exp_t e;
                n_cal++;
                len = 1;
                if (expq.size() == 0) begin
                    chk(1'b0, "R11 unexpected calibration", 1, 0);
                end else begin
                    e = expq.pop_front();
                    chk(trim_go == e.trim, "R8/R9/R10 trim pulse", int'(trim_go), int'(e.trim));
                    chk(dclk_oe == e.keep, "R8/R9/R10 dclk enable", int'(dclk_oe), int'(e.keep));
                    chk(data_oe == 1'b0, "R7 data disabled", int'(data_oe), 0);
                end
            end else if (cal_busy) begin
                len++;
                if (trim_go || data_oe) chk(1'b0, "R7/R8 mid-interval outputs", int'({trim_go, data_oe}), 0);
            end else if (prev_busy) begin
                chk(len == CALN, "R7 interval length", len, CALN);
            end
            prev_busy <= cal_busy;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && !(cal_busy == 1'b0 && prev_busy == 1'b0); i++) @(negedge clk);
        cycles(2);
    endtask

    task automatic pin_cycle(input int hi_len);
        cal_pin = 1'b0; cycles(10);
        cal_pin = 1'b1; cycles(hi_len);
    endtask

    // returns cycles until cal_busy rises, or -1
    task automatic wait_start(input int maxc, output int t);
        t = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (cal_busy) begin t = i; break; end
        end
    endtask

    initial begin
        int t, n0;
        // R1 reset state
        rst = 1'b1; cycles(3);
        chk(!cal_busy && data_oe && dclk_oe && !trim_go, "R1 reset outputs",
            int'({cal_busy, data_oe, dclk_oe, trim_go}), 6);
        rst = 1'b0; cycles(1);
        chk(!cal_busy && data_oe && dclk_oe && !trim_go, "R1 after reset",
            int'({cal_busy, data_oe, dclk_oe, trim_go}), 6);
        // R2 clock not valid: no progress
        cycles(150);
        chk(n_cal == 0, "R2 no calibration without clk_ok", n_cal, 0);
        expq.push_back('{trim: 1'b1, keep: 1'b0});
        clk_ok = 1'b1;
        wait_start(SHORT + 20, t);
        chk(t >= SHORT && t <= SHORT + 4, "R2 short delay window", t, SHORT);
        wait_idle();
        // R5 + R8: on-command cal, keep_dclk=0
        n0 = n_cal;
        expq.push_back('{trim: 1'b1, keep: 1'b0});
        pin_cycle(12);
        wait_idle();
        chk(n_cal == n0 + 1, "R5 command calibration", n_cal, n0 + 1);
        cal_pin = 1'b0; cycles(10);
        // R9: keep_dclk=1
        keep_dclk = 1'b1;
        expq.push_back('{trim: 1'b0, keep: 1'b1});
        pin_cycle(12);
        wait_idle();
        chk(n_cal == n0 + 2, "R9 keep-clock calibration", n_cal, n0 + 2);
        // R6 glitch rejection
        cal_pin = 1'b0; cycles(10);
        cal_pin = 1'b1; cycles(2);
        cal_pin = 1'b0; cycles(40);
        chk(n_cal == n0 + 2, "R6 short pulse ignored", n_cal, n0 + 2);
        // R11: trigger during running calibration
        keep_dclk = 1'b0;
        expq.push_back('{trim: 1'b1, keep: 1'b0});
        cal_pin = 1'b1;
        wait_start(30, t);
        cal_pin = 1'b0; cycles(7);
        cal_pin = 1'b1; cycles(7);
        cal_pin = 1'b0;
        wait_idle(); cycles(40);
        chk(n_cal == n0 + 3, "R11 trigger during calibration ignored", n_cal, n0 + 3);
        chk(expq.size() == 0, "R11 scoreboard drained", expq.size(), 0);

        // R4 + R10 + R3: pin high at power-up, long delay, keep bit set
        cal_pin = 1'b1; dly_long = 1'b1; keep_dclk = 1'b1;
        do_reset();
        n0 = n_cal;
        cycles(LONG + 60);
        chk(n_cal == n0, "R4 held off while pin stays high", n_cal, n0);
        expq.push_back('{trim: 1'b1, keep: 1'b0});
        pin_cycle(2);
        wait_start(30, t);
        chk(t > 0, "R4 calibration after low-high cycle", t, 1);
        wait_idle();
        chk(n_cal == n0 + 1, "R10 power-up trim despite keep bit", n_cal, n0 + 1);

        // R3 long delay honoured
        cal_pin = 1'b0; keep_dclk = 1'b0;
        expq.push_back('{trim: 1'b1, keep: 1'b0});
        do_reset();
        wait_start(LONG + 20, t);
        chk(t >= LONG && t <= LONG + 4, "R3 long delay window", t, LONG);
        wait_idle();

        // R3 serial mode forces short delay
        ser_cfg = 1'b1;
        expq.push_back('{trim: 1'b1, keep: 1'b0});
        do_reset();
        wait_start(LONG + 20, t);
        chk(t >= SHORT && t <= SHORT + 4, "R3 serial mode short delay", t, SHORT);
        wait_idle();
        chk(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cycles(20000);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule